// File: doc/BRIEF.md
# Link Data Rate Upgrade Controller

This block decides when a serial link moves from its base data rate (2.5 GT/s) to the doubled rate (5.0 GT/s). Full training from Detect always runs at the base rate. An upgrade is attempted only when four conditions hold together: the physical training state machine is in its active state, the data-link layer reports active, the local side offers the higher rate, and the partner offers it too. When the upgrade starts, the block raises a one-cycle retrain request and switches a rate select that is fanned out identically to every lane.

The analog side (clock switching, equalization) is outside the block. It is represented by a "change complete" input. While the change is in progress the block holds its data-link-up output high, so the speed change can never appear as a link-down event. If completion does not arrive within a parameterised number of cycles, the block falls back to the base rate. It then stays there until the next full training.

A two-bit status output reports the rate in use.

Top module: `link_rate_ctrl`

## Requirements
- R1: After synchronous reset every lane select is 0 (base rate), the rate status reads 1, and the retrain request is low.
- R2: All bits of the per-lane rate select always carry the same value: all zeros (base) or all ones (high).
- R3: The lane select does not leave the base rate unless the physical-active, data-link-active, local-capable and partner-capable inputs were all high in the cycle before the change starts. From base, an upgrade takes two clock edges with all four held high.
- R4: At the start of a change, the lane select goes to all ones and the retrain request is high for exactly one cycle.
- R5: A change-complete input seen during a change moves the link to the high rate on the next edge. This holds even in the same cycle the timeout would expire.
- R6: While a change is in progress (lane select high, status 1), the data-link-up output stays 1 whatever the data-link-active input does. Outside a change it follows that input.
- R7: If no completion arrives within TIMEOUT_CYC cycles of a change starting, the lane select returns to base. No new attempt is made, even with all conditions held, until a full retrain.
- R8: A full-retrain pulse returns the block to base on the next edge from any state. It also clears the no-retry lock from R7.
- R9: The rate status is 2'd1 at the base rate and during a change, and 2'd2 only at the high rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_active_i | input | 1 | Training state machine is in its active state |
| dl_active_i | input | 1 | Data-link layer is active |
| local_hi_cap_i | input | 1 | Local side offers the higher rate |
| peer_hi_cap_i | input | 1 | Partner offers the higher rate |
| full_retrain_i | input | 1 | Full training from Detect is starting |
| rate_done_i | input | 1 | Analog rate change has completed |
| lane_rate_o | output | LANES | Per-lane rate select, 1 = high rate |
| retrain_req_o | output | 1 | One-cycle request for the speed-change retrain |
| dl_up_o | output | 1 | Data-link-up indication, held through a change |
| cur_rate_o | output | 2 | Rate status: 1 base, 2 high |

## Verification
The bench builds the block with LANES=4 and TIMEOUT_CYC=4. The short timeout makes the expiry edge reachable in a few cycles and places it next to the completion input for the priority case. The four gating inputs are swept through all fifteen combinations that lack at least one condition, and each is held for several cycles to show that no upgrade starts. The sequence then walks every state-to-state move, including the locked state after a timeout and its release by a full retrain.

// File: rtl/lrc_pkg.sv
// Shared types for the link rate controller.
// Assumes two rates only: base and doubled.
package lrc_pkg;
    typedef enum logic [1:0] {
        ST_BASE        = 2'd0,
        ST_WAIT_ACTIVE = 2'd1,
        ST_CHANGING    = 2'd2,
        ST_HIGH        = 2'd3
    } lrc_state_e;

    localparam logic [1:0] RATE_CODE_BASE = 2'd1;
    localparam logic [1:0] RATE_CODE_HIGH = 2'd2;
endpackage

// File: rtl/lrc_timeout.sv
// Cycle counter bounding how long a rate change may take.
// Counts while run_i is high, clears when it is low; expired_o marks the
// LIMIT-th cycle of a run. Assumes LIMIT >= 2.
module lrc_timeout #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Advance while a change runs, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final allowed cycle.
    always_comb begin
        expired_o = run_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/lrc_fsm.sv
// Rate upgrade state machine: base, waiting for data-link active,
// changing, high. A timeout during a change locks out retries until a
// full retrain. Assumes all inputs are synchronous to clk.
module lrc_fsm
    import lrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phy_active_i,
    input  logic       dl_active_i,
    input  logic       local_hi_cap_i,
    input  logic       peer_hi_cap_i,
    input  logic       full_retrain_i,
    input  logic       rate_done_i,
    input  logic       expired_i,
    output lrc_state_e state_o,
    output logic       retrain_req_o
);
    lrc_state_e state_q, state_d;
    logic       locked_q, locked_d;
    logic       go_up;

    // All four conditions for an upgrade attempt.
    always_comb begin
        go_up = phy_active_i && dl_active_i && local_hi_cap_i
                && peer_hi_cap_i && !locked_q;
    end

    // Next-state and lock decision.
    always_comb begin
        state_d  = state_q;
        locked_d = locked_q;
        if (full_retrain_i) begin
            state_d  = ST_BASE;
            locked_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_BASE: begin
                    if (phy_active_i) state_d = ST_WAIT_ACTIVE;
                end
                ST_WAIT_ACTIVE: begin
                    if (!phy_active_i) state_d = ST_BASE;
                    else if (go_up)    state_d = ST_CHANGING;
                end
                ST_CHANGING: begin
                    if (rate_done_i) begin
                        state_d = ST_HIGH;
                    end else if (expired_i) begin
                        state_d  = ST_BASE;
                        locked_d = 1'b1;
                    end
                end
                ST_HIGH: state_d = ST_HIGH;
                default: state_d = ST_BASE;
            endcase
        end
    end

    // State, lock and retrain pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_BASE;
            locked_q      <= 1'b0;
            retrain_req_o <= 1'b0;
        end else begin
            state_q       <= state_d;
            locked_q      <= locked_d;
            retrain_req_o <= (state_d == ST_CHANGING) && (state_q != ST_CHANGING);
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/lrc_lane_fanout.sv
// Copies the single rate decision onto every lane so lanes never differ.
module lrc_lane_fanout #(
    parameter int LANES = 8
) (
    input  logic             high_i,
    output logic [LANES-1:0] lane_rate_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One identical select per lane.
        assign lane_rate_o[g] = high_i;
    end
endmodule

// File: rtl/link_rate_ctrl.sv
// Top of the link data rate upgrade controller. Holds base rate through
// training, upgrades after physical and data-link active with both sides
// capable, and keeps data-link-up high during the change.
// Assumes synchronous active-low reset and synchronous inputs.
module link_rate_ctrl
    import lrc_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phy_active_i,
    input  logic             dl_active_i,
    input  logic             local_hi_cap_i,
    input  logic             peer_hi_cap_i,
    input  logic             full_retrain_i,
    input  logic             rate_done_i,
    output logic [LANES-1:0] lane_rate_o,
    output logic             retrain_req_o,
    output logic             dl_up_o,
    output logic [1:0]       cur_rate_o
);
    lrc_state_e state;
    logic       changing;
    logic       expired;

    lrc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .phy_active_i   (phy_active_i),
        .dl_active_i    (dl_active_i),
        .local_hi_cap_i (local_hi_cap_i),
        .peer_hi_cap_i  (peer_hi_cap_i),
        .full_retrain_i (full_retrain_i),
        .rate_done_i    (rate_done_i),
        .expired_i      (expired),
        .state_o        (state),
        .retrain_req_o  (retrain_req_o)
    );

    lrc_timeout #(.LIMIT(TIMEOUT_CYC)) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (changing),
        .expired_o (expired)
    );

    lrc_lane_fanout #(.LANES(LANES)) u_fanout (
        .high_i      (changing || (state == ST_HIGH)),
        .lane_rate_o (lane_rate_o)
    );

    // Decode change phase, status code and held link-up indication.
    always_comb begin
        changing   = (state == ST_CHANGING);
        cur_rate_o = (state == ST_HIGH) ? RATE_CODE_HIGH : RATE_CODE_BASE;
        dl_up_o    = dl_active_i || changing;
    end
endmodule

// File: rtl/link_rate_ctrl_chk.sv
// Port-level checker for link_rate_ctrl, attached with bind below.
module link_rate_ctrl_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phy_active_i,
    input logic             dl_active_i,
    input logic             local_hi_cap_i,
    input logic             peer_hi_cap_i,
    input logic             full_retrain_i,
    input logic             rate_done_i,
    input logic [LANES-1:0] lane_rate_o,
    input logic             retrain_req_o,
    input logic             dl_up_o,
    input logic [1:0]       cur_rate_o
);
    logic in_change;
    assign in_change = lane_rate_o[0] && (cur_rate_o == 2'd1);

    // Lanes agree after reset.
    always @(negedge clk) begin
        if (rst_n) begin
            assert_lanes_uniform_R2: assert (lane_rate_o == '0 || lane_rate_o == '1);
        end
    end

    assert_gated_upgrade_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_rate_o[0]) |-> $past(phy_active_i && dl_active_i
                                        && local_hi_cap_i && peer_hi_cap_i));

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req_o |=> !retrain_req_o);

    assert_req_with_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req_o |-> in_change);

    assert_done_to_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_change && rate_done_i && !full_retrain_i) |=> (cur_rate_o == 2'd2));

    assert_link_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_change |-> dl_up_o);

    assert_retrain_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_retrain_i |=> (lane_rate_o == '0 && cur_rate_o == 2'd1));

    assert_rate_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_rate_o == 2'd1) || (cur_rate_o == 2'd2 && lane_rate_o[0]));
endmodule

bind link_rate_ctrl link_rate_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .phy_active_i   (phy_active_i),
    .dl_active_i    (dl_active_i),
    .local_hi_cap_i (local_hi_cap_i),
    .peer_hi_cap_i  (peer_hi_cap_i),
    .full_retrain_i (full_retrain_i),
    .rate_done_i    (rate_done_i),
    .lane_rate_o    (lane_rate_o),
    .retrain_req_o  (retrain_req_o),
    .dl_up_o        (dl_up_o),
    .cur_rate_o     (cur_rate_o)
);

// File: tb/link_rate_ctrl_tb.sv
`timescale 1ns/1ps
module link_rate_ctrl_tb;
    localparam int LANES = 4;
    localparam int TO    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             phy = 1'b0, dl = 1'b0, lcap = 1'b0, pcap = 1'b0;
    logic             fr = 1'b0, done = 1'b0;
    logic [LANES-1:0] lane_rate;
    logic             req, dl_up;
    logic [1:0]       cur;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    link_rate_ctrl #(.LANES(LANES), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .phy_active_i(phy), .dl_active_i(dl),
        .local_hi_cap_i(lcap), .peer_hi_cap_i(pcap), .full_retrain_i(fr),
        .rate_done_i(done), .lane_rate_o(lane_rate), .retrain_req_o(req),
        .dl_up_o(dl_up), .cur_rate_o(cur)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare the outputs against the state the requirements predict.
    task automatic expect_rate(input bit high, input logic [1:0] code,
                               input bit exp_req, input string tag);
        logic [LANES-1:0] exp_l;
        exp_l = high ? {LANES{1'b1}} : '0;
        checks++;
        if (lane_rate !== exp_l || cur !== code || req !== exp_req) begin
            errors++;
            $display("FAIL %s: lanes=%b cur=%0d req=%b expected lanes=%b cur=%0d req=%b",
                     tag, lane_rate, cur, req, exp_l, code, exp_req);
        end
    endtask

    task automatic expect_dl(input bit exp, input string tag);
        checks++;
        if (dl_up !== exp) begin
            errors++;
            $display("FAIL %s: dl_up=%b expected %b", tag, dl_up, exp);
        end
    endtask

    task automatic pulse_retrain();
        fr = 1'b1;
        step();
        fr = 1'b0;
    endtask

    task automatic set_conds(input logic [3:0] m);
        {phy, dl, lcap, pcap} = m;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1: reset state
        expect_rate(0, 2'd1, 0, "R1 reset");
        expect_dl(0, "R1 reset dl_up");
        rst_n = 1'b1;
        step();
        expect_rate(0, 2'd1, 0, "R1 after release");

        // R3: every combination lacking a condition keeps the base rate
        for (int m = 0; m < 15; m++) begin
            pulse_retrain();
            set_conds(4'(m));
            for (int c = 0; c < 4; c++) begin
                step();
                expect_rate(0, 2'd1, 0, "R3 gated sweep");
            end
        end

        // R3/R4: all conditions -> change after two edges
        pulse_retrain();
        set_conds(4'hF);
        step();
        expect_rate(0, 2'd1, 0, "R3 one edge not enough");
        step();
        expect_rate(1, 2'd1, 1, "R4 change start");     // cycle 0 of change
        expect_dl(1, "R6 dl_up at change start");
        step();
        expect_rate(1, 2'd1, 0, "R4 single pulse R2");  // cycle 1
        // R6: data-link input drops during the change
        dl = 1'b0; phy = 1'b0;
        #1 expect_dl(1, "R6 held while changing");
        step();                                          // cycle 2
        expect_dl(1, "R6 held next cycle");
        expect_rate(1, 2'd1, 0, "R9 code during change");
        dl = 1'b1; phy = 1'b1; done = 1'b1;
        step();
        done = 1'b0;
        expect_rate(1, 2'd2, 0, "R5 high after done");
        step(); step();
        expect_rate(1, 2'd2, 0, "R5 stays high");
        dl = 1'b0;
        #1 expect_dl(0, "R6 follows input outside change");
        dl = 1'b1;

        // R8: retrain from high returns to base
        pulse_retrain();
        expect_rate(0, 2'd1, 0, "R8 from high");
        step();
        step();
        expect_rate(1, 2'd1, 1, "R8 re-upgrade start");
        // R7: no done -> expiry after TO cycles of change
        for (int c = 1; c < TO; c++) begin
            step();
            expect_rate(1, 2'd1, 0, "R7 still changing");
        end
        step();
        expect_rate(0, 2'd1, 0, "R7 reverted");
        for (int c = 0; c < 10; c++) begin
            step();
            expect_rate(0, 2'd1, 0, "R7 no retry");
        end

        // R8: retrain clears the lock
        pulse_retrain();
        step();
        step();
        expect_rate(1, 2'd1, 1, "R8 lock cleared");
        for (int c = 1; c < TO; c++) step();
        // R5: done on the expiry cycle wins
        done = 1'b1;
        step();
        done = 1'b0;
        expect_rate(1, 2'd2, 0, "R5 done beats timeout");

        // R8: retrain from waiting state
        pulse_retrain();
        set_conds(4'b1000);
        step();
        pulse_retrain();
        expect_rate(0, 2'd1, 0, "R8 from wait");

        finish_run();
    end
endmodule